// File: doc/BRIEF.md
# Sixteen-Bit Execute Unit with Relational Flags

This block is the arithmetic and logic stage of a small 16-bit processor core. Each cycle it can accept one operation: an operation select, a first operand taken from a register, a second operand that the surrounding pipeline has already resolved from either a register or an immediate, and the current processor flags word. One clock later it presents either a 16-bit result for writeback or a rewritten flags word, together with a strobe that says which of the two the pipeline should commit.

The result operations cover bitwise logic, logical shifts in both directions, wrapping add and subtract, and the low half of unsigned and signed products. Shifts and subtract also come in reversed forms, where the two operands trade roles. This lets a compiler put an immediate on either side without spending a move. The compare operation produces no result. Instead it rewrites five relation bits of the flags word (equal, unsigned below and above, signed less and greater) and carries every other flags bit through untouched.

Register-file reads, immediate fetch, instruction decode and writeback sequencing belong to the surrounding core.

Top module: `alu16_exec`

## Requirements
- R1: Operation codes on `op_sel` are OR=0, AND=1, XOR=2, SHL=3, RSHL=4, SHR=5, RSHR=6, ADD=7, SUB=8, RSUB=9, MUL=10, IMUL=11, CMP=12. Outputs are registered and appear on the clock edge after the one that samples `in_valid`. `result_valid` is high for a valid op 0 to 11, `flags_we` is high for a valid op 12, and the two are never high together.
- R2: OR, AND and XOR return the bitwise combination of `opnd_a` and `opnd_b`.
- R3: SHL returns `opnd_a` shifted left by `opnd_b` and SHR returns `opnd_a` shifted right logically (zero fill) by `opnd_b`. A shift amount of 16 or more returns zero.
- R4: RSHL and RSHR swap the operand roles: `opnd_b` is shifted by `opnd_a`, with the same zero fill and the same saturation at 16 or more.
- R5: ADD returns a+b, SUB returns a-b and RSUB returns b-a, each wrapped to the low 16 bits.
- R6: MUL returns the low 16 bits of the unsigned product. IMUL returns the low 16 bits of the product of both operands read as two's-complement values.
- R7: CMP sets flags bit 0 when a equals b and clears it otherwise.
- R8: CMP sets flags bit 1 when a is below b as unsigned numbers and bit 2 when a is above b as unsigned numbers, and clears each bit when its relation is false.
- R9: CMP sets flags bit 3 when a is less than b as signed numbers and bit 4 when a is greater than b as signed numbers, and clears each bit when its relation is false.
- R10: CMP leaves every flags bit above bit 4 equal to the corresponding bit of `flags_in`.
- R11: Every operation other than a valid CMP gives `flags_out` equal to `flags_in`. A CMP, an unused code (13 to 15) or an idle cycle gives `result` zero. An unused code raises neither strobe.
- R12: While `rst_n` is low, `result`, `flags_out`, `result_valid` and `flags_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (see R1) |
| opnd_a | input | 16 | First operand (register value) |
| opnd_b | input | 16 | Second operand (register value or immediate) |
| flags_in | input | 16 | Current flags word |
| result | output | 16 | Registered operation result |
| flags_out | output | 16 | Registered flags word, updated only by compare |
| result_valid | output | 1 | `result` should be written back |
| flags_we | output | 1 | `flags_out` should be committed |

## Verification
The embedded properties watch, on every cycle, the relationships that hold whatever the operands are. The strobes are exclusive and follow a sampled valid op. A compare asserts exactly one of equal, below and above, and exactly one of equal, less and greater. The upper flags bits always pass through, and the whole flags word passes through on any non-compare cycle. A shift by 16 or more gives zero. Arithmetic correctness cannot be shown by such properties: the wrap of add and subtract, the reversed operand roles, the low half of signed products, and the split between the signed and unsigned relations at the sign boundary only show up in the bench's sweep of corner operands against values it computes itself.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_OR   = 4'd0,
        OP_AND  = 4'd1,
        OP_XOR  = 4'd2,
        OP_SHL  = 4'd3,
        OP_RSHL = 4'd4,
        OP_SHR  = 4'd5,
        OP_RSHR = 4'd6,
        OP_ADD  = 4'd7,
        OP_SUB  = 4'd8,
        OP_RSUB = 4'd9,
        OP_MUL  = 4'd10,
        OP_IMUL = 4'd11,
        OP_CMP  = 4'd12
    } alu_op_e;

    localparam int OP_W = 4;

    // Relation flag positions inside the flags word
    localparam int FLG_EQ = 0;
    localparam int FLG_BE = 1;
    localparam int FLG_AB = 2;
    localparam int FLG_LT = 3;
    localparam int FLG_GT = 4;
    localparam int FLG_N  = 5;

    typedef struct packed {
        logic gt;
        logic lt;
        logic ab;
        logic be;
        logic eq;
    } rel_flags_t;

endpackage

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b1
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] amt,
    output logic [WIDTH-1:0] dout
);
    localparam int SHW = $clog2(WIDTH);

    logic [SHW:0][WIDTH-1:0] stg;
    logic [WIDTH-1:0]        src_oriented;
    logic [WIDTH-1:0]        res_oriented;
    logic                    too_far;

    // Right shifts reuse the left-shift ladder on a bit-reversed word.
    generate
        if (LEFT) begin : g_left
            assign src_oriented = din;
            assign dout         = too_far ? '0 : res_oriented;
        end else begin : g_right
            for (genvar k = 0; k < WIDTH; k++) begin : g_rev
                assign src_oriented[k] = din[WIDTH-1-k];
            end
            logic [WIDTH-1:0] res_back;
            for (genvar k = 0; k < WIDTH; k++) begin : g_unrev
                assign res_back[k] = res_oriented[WIDTH-1-k];
            end
            assign dout = too_far ? '0 : res_back;
        end
    endgenerate

    assign stg[0] = src_oriented;

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
        end
    endgenerate

    assign res_oriented = stg[SHW];
    assign too_far      = |amt[WIDTH-1:SHW];

endmodule

// File: rtl/alu16_mult.sv
module alu16_mult #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic [WIDTH-1:0] prod_lo
);
    // Truncated shift-add array: only the low WIDTH bits are formed.
    // The low half of a two's-complement product equals the low half of
    // the unsigned product, so one array serves both multiply ops.
    logic [WIDTH:0][WIDTH-1:0] acc;

    assign acc[0] = '0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_row
            logic [WIDTH-1:0] pp;
            assign pp       = mplier[i] ? (mcand << i) : '0;
            assign acc[i+1] = acc[i] + pp;
        end
    endgenerate

    assign prod_lo = acc[WIDTH];

endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output rel_flags_t       rel
);
    logic [WIDTH-1:0] lhs_biased;
    logic [WIDTH-1:0] rhs_biased;

    // Flipping the sign bit maps two's-complement order onto unsigned order.
    assign lhs_biased = {~lhs[WIDTH-1], lhs[WIDTH-2:0]};
    assign rhs_biased = {~rhs[WIDTH-1], rhs[WIDTH-2:0]};

    always_comb begin
        rel.eq = (lhs == rhs);
        rel.be = (lhs < rhs);
        rel.ab = (lhs > rhs);
        rel.lt = (lhs_biased < rhs_biased);
        rel.gt = (lhs_biased > rhs_biased);
    end

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
    import alu16_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int FLAGS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         op_sel,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [FLAGS_W-1:0] flags_in,
    output logic [WIDTH-1:0]   result,
    output logic [FLAGS_W-1:0] flags_out,
    output logic               result_valid,
    output logic               flags_we
);
    localparam logic [FLAGS_W-1:0] REL_MASK = FLAGS_W'((1 << FLG_N) - 1);

    typedef struct packed {
        logic [WIDTH-1:0]   res;
        logic [FLAGS_W-1:0] flg;
        logic               rvld;
        logic               fwe;
    } stage_t;

    stage_t st_d, st_q;

    alu_op_e          op;
    logic             swap;
    logic [WIDTH-1:0] x_opnd;
    logic [WIDTH-1:0] y_opnd;
    logic [WIDTH-1:0] shl_res;
    logic [WIDTH-1:0] shr_res;
    logic [WIDTH-1:0] mul_res;
    rel_flags_t       rel;

    assign op = alu_op_e'(op_sel);

    // Reversed forms feed the same datapath with the operands exchanged.
    always_comb begin
        swap   = (op == OP_RSHL) || (op == OP_RSHR) || (op == OP_RSUB);
        x_opnd = swap ? opnd_b : opnd_a;
        y_opnd = swap ? opnd_a : opnd_b;
    end

    alu16_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .din  (x_opnd),
        .amt  (y_opnd),
        .dout (shl_res)
    );

    alu16_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .din  (x_opnd),
        .amt  (y_opnd),
        .dout (shr_res)
    );

    alu16_mult #(.WIDTH(WIDTH)) u_mul (
        .mcand   (opnd_a),
        .mplier  (opnd_b),
        .prod_lo (mul_res)
    );

    alu16_cmp #(.WIDTH(WIDTH)) u_cmp (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .rel (rel)
    );

    always_comb begin
        st_d      = '0;
        st_d.flg  = flags_in;
        if (in_valid) begin
            st_d.rvld = 1'b1;
            unique case (op_sel)
                OP_OR:            st_d.res = opnd_a | opnd_b;
                OP_AND:           st_d.res = opnd_a & opnd_b;
                OP_XOR:           st_d.res = opnd_a ^ opnd_b;
                OP_SHL, OP_RSHL:  st_d.res = shl_res;
                OP_SHR, OP_RSHR:  st_d.res = shr_res;
                OP_ADD:           st_d.res = x_opnd + y_opnd;
                OP_SUB, OP_RSUB:  st_d.res = x_opnd - y_opnd;
                OP_MUL, OP_IMUL:  st_d.res = mul_res;
                OP_CMP: begin
                    st_d.rvld = 1'b0;
                    st_d.fwe  = 1'b1;
                    st_d.flg  = (flags_in & ~REL_MASK)
                              | FLAGS_W'(rel);
                end
                default:          st_d.rvld = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign flags_out    = st_q.flg;
    assign result_valid = st_q.rvld;
    assign flags_we     = st_q.fwe;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && flags_we)); // R1

    AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid || flags_we) |-> $past(in_valid)); // R1

    AST_EQ_BE_AB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> $countones({flags_out[FLG_EQ], flags_out[FLG_BE], flags_out[FLG_AB]}) == 1); // R8

    AST_EQ_LT_GT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> $countones({flags_out[FLG_EQ], flags_out[FLG_LT], flags_out[FLG_GT]}) == 1); // R9

    AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[FLG_EQ] == ($past(opnd_a) == $past(opnd_b)))); // R7

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_out & ~REL_MASK) == ($past(flags_in) & ~REL_MASK))); // R10

    AST_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !flags_we) |-> (flags_out == $past(flags_in))); // R11

    AST_SHIFT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(op_sel) == OP_SHL || $past(op_sel) == OP_SHR)
         && ($past(opnd_b) >= WIDTH)) |-> (result == '0)); // R3

    AST_CMP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (result == '0)); // R11

endmodule

// File: tb/test_alu16_exec.sv
module test_alu16_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] flags_in = '0;
    logic [15:0] result;
    logic [15:0] flags_out;
    logic        result_valid;
    logic        flags_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    alu16_exec i_alu16_exec (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_sel       (op_sel),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .flags_in     (flags_in),
        .result       (result),
        .flags_out    (flags_out),
        .result_valid (result_valid),
        .flags_we     (flags_we)
    );

    function automatic string req_of(input logic [3:0] op, input bit vld);
        if (!vld || op > 4'd12) return "R11";
        case (op)
            4'd0, 4'd1, 4'd2:  return "R2";
            4'd3, 4'd5:        return "R3";
            4'd4, 4'd6:        return "R4";
            4'd7, 4'd8, 4'd9:  return "R5";
            4'd10, 4'd11:      return "R6";
            default:           return "R7/R8/R9/R10";
        endcase
    endfunction

    function automatic logic [15:0] model_res(input logic [3:0] op,
                                              input logic [15:0] a,
                                              input logic [15:0] b);
        logic signed [31:0] sp;
        case (op)
            4'd0:  return a | b;
            4'd1:  return a & b;
            4'd2:  return a ^ b;
            4'd3:  return (b >= 16) ? 16'h0 : 16'(a << b[3:0]);
            4'd4:  return (a >= 16) ? 16'h0 : 16'(b << a[3:0]);
            4'd5:  return (b >= 16) ? 16'h0 : (a >> b[3:0]);
            4'd6:  return (a >= 16) ? 16'h0 : (b >> a[3:0]);
            4'd7:  return 16'(a + b);
            4'd8:  return 16'(a - b);
            4'd9:  return 16'(b - a);
            4'd10: return 16'(32'(a) * 32'(b));
            4'd11: begin
                sp = 32'(signed'(a)) * 32'(signed'(b));
                return sp[15:0];
            end
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] model_flg(input logic [3:0] op,
                                              input bit vld,
                                              input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic [15:0] f);
        logic [4:0] r;
        if (!vld || op != 4'd12) return f;
        r[0] = (a == b);
        r[1] = (a < b);
        r[2] = (a > b);
        r[3] = ($signed(a) < $signed(b));
        r[4] = ($signed(a) > $signed(b));
        return {f[15:5], r};
    endfunction

    task automatic apply(input bit vld, input logic [3:0] op,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] f);
        logic [15:0] e_res, e_flg;
        bit e_rv, e_we;
        in_valid = vld; op_sel = op; opnd_a = a; opnd_b = b; flags_in = f;
        e_rv  = vld && (op <= 4'd11);
        e_we  = vld && (op == 4'd12);
        e_res = e_rv ? model_res(op, a, b) : 16'h0;
        e_flg = model_flg(op, vld, a, b, f);
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result !== e_res || flags_out !== e_flg
            || result_valid !== e_rv || flags_we !== e_we) begin
            n_fails++;
            $display("FAIL %s (R1 strobes) op=%0d a=%h b=%h f=%h: got res=%h flg=%h rv=%b we=%b, expected res=%h flg=%h rv=%b we=%b",
                     req_of(op, vld), op, a, b, f, result, flags_out, result_valid,
                     flags_we, e_res, e_flg, e_rv, e_we);
        end
    endtask

    function automatic logic [15:0] corner(input int k);
        case (k)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h0007;  4: return 16'h000F;  5: return 16'h0010;
            6: return 16'h0011;  7: return 16'h00FF;  8: return 16'h1234;
            9: return 16'h7FFE;  10: return 16'h7FFF; 11: return 16'h8000;
            12: return 16'h8001; 13: return 16'hA5C3; 14: return 16'hFFFE;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        // R12: outputs held at zero during reset
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1; op_sel = 4'd7; opnd_a = 16'h1111; opnd_b = 16'h2222;
        flags_in = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result !== 16'h0 || flags_out !== 16'h0 || result_valid !== 1'b0
            || flags_we !== 1'b0) begin
            n_fails++;
            $display("FAIL R12 reset: got res=%h flg=%h rv=%b we=%b, expected all zero",
                     result, flags_out, result_valid, flags_we);
        end
        rst_n = 1'b1;

        // Corner sweep over every defined op (R2..R10, R1 strobes)
        for (int op = 0; op <= 12; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    seed = lcg(seed);
                    apply(1'b1, 4'(op), corner(i), corner(j), seed[31:16]);
                end
            end
        end

        // Unused codes and idle cycles (R11)
        for (int op = 13; op <= 15; op++) begin
            for (int i = 0; i < 16; i++) begin
                seed = lcg(seed);
                apply(1'b1, 4'(op), corner(i), corner(15 - i), seed[31:16]);
            end
        end
        for (int i = 0; i < 16; i++) begin
            seed = lcg(seed);
            apply(1'b0, 4'(i % 13), corner(i), corner(i), seed[31:16]);
        end

        // Random operands, back-to-back (R1 latency, all ops)
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra, rb, rf;
            seed = lcg(seed); ra = seed[31:16];
            seed = lcg(seed); rb = seed[31:16];
            seed = lcg(seed); rf = seed[31:16];
            if (seed[3:0] == 4'd0) rb = ra;
            apply(1'b1, 4'(seed[15:8] % 13), ra, rb, rf);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: got run still active, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule